// File: doc/BRIEF.md
# Management Serial Bus Master (Clause 22 / Clause 45)

This block is a register-programmed master for the two-wire PHY management bus. A host fills in a mode register, a target register (PHY address plus register or device number) and a payload register, then writes a command word with a start bit. The block generates the management clock from the system clock and shifts out a complete frame: preamble, start code, opcode, addresses, turnaround and 16 data bits. For read frames it releases the data line during turnaround and data, and it captures the 16 bits that the PHY returns.

Both Clause 22 and Clause 45 framing are supported, chosen by a mode bit. A Clause 45 access takes two host commands. An address frame carries the 16-bit register address from the payload register. A read or write frame follows once busy has cleared, and for a write the host first refills the payload register with the write data. The host polls a busy bit in the command register and then reads the captured value.

Top module: `mgmt_ser_master`

## Requirements
- R1: Registers sit at byte offsets 0x40 (mode: bit 8 = Clause 45 select, bits 3:0 = clock divide), 0x44 (bits 12:8 PHY address, bits 4:0 register or device number), 0x48 (bits 15:0 payload), 0x4C (bits 15:0 captured read data) and 0x50 (bit 16 busy). Only these fields are stored and read back. All other bits read 0, and every register reads 0 after reset.
- R2: A write to 0x50 with bit 8 set and a valid code in bits 1:0 starts a frame while idle. Busy reads 1 from the next clock until the frame's last management clock falls, and then reads 0.
- R3: A start written while busy is set is ignored: no second frame is sent.
- R4: In Clause 22 mode, code 0 sends a read frame: 32 ones, start 01, opcode 10, 5-bit PHY address, 5-bit register number, then the line is released for turnaround and data.
- R5: In Clause 22 mode, code 1 sends a write frame: 32 ones, 01, opcode 01, PHY address, register number, turnaround 10, and the 16 payload bits, most significant bit first.
- R6: In Clause 45 mode, code 0 sends an address frame: 32 ones, start 00, opcode 00, PHY address, device number, 10, and the payload register as the 16-bit register address.
- R7: In Clause 45 mode, code 1 sends a write frame (opcode 01, payload as data) and code 2 a read frame (opcode 11), both with start 00.
- R8: Read data is sampled on rising management clock edges during the 16 data bit times, most significant bit first. It appears in 0x4C bits 15:0 once busy clears, with bits 31:16 zero, and stays unchanged while idle.
- R9: With divide value N, each management clock phase lasts N+1 system clocks, so a frame keeps busy set for 128*(N+1) clocks. The management clock is low while idle, and the data line changes only as the management clock falls.
- R10: Codes 2 and 3 in Clause 22 mode, and code 3 in Clause 45 mode, are ignored: busy stays 0 and no frame is sent.
- R11: During the turnaround and data bits of any read frame, the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset for read and write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A table of accesses covers every legal code in both modes, with different PHY and register numbers, payloads and divide values. Each access's serial frame, as seen by a PHY model, is compared bit by bit, so a wrong start code, opcode or field order in one mode shows up even when the other mode is right. Read accesses use asymmetric return patterns such as 0xA5C3, which expose bit reversal or an off-by-one in capture. Directed cases cover the reset values, start during busy, illegal codes, and the busy length for each divide value.

// File: rtl/mgmt_ser_pkg.sv
package mgmt_ser_pkg;
  localparam int REG_W = 32;
  localparam int PAY_W = 16;
  localparam int FLD_W = 5;
  localparam int DIV_W = 4;
  localparam int PRE_BITS = 32;
  localparam int FRM_BITS = PRE_BITS + 2 + 2 + 2 * FLD_W + 2 + PAY_W;
  localparam int IDX_W = $clog2(FRM_BITS);

  localparam logic [7:0] OFS_MODE = 8'h40;
  localparam logic [7:0] OFS_TGT  = 8'h44;
  localparam logic [7:0] OFS_PAY  = 8'h48;
  localparam logic [7:0] OFS_RX   = 8'h4C;
  localparam logic [7:0] OFS_CMD  = 8'h50;

  typedef struct packed {
    logic                          rd;
    logic [FRM_BITS-PRE_BITS-1:0]  word;
  } frame_req_t;
endpackage

// File: rtl/mgmt_ser_regs.sv
module mgmt_ser_regs
  import mgmt_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             busy,
  input  logic [PAY_W-1:0] rx_data,
  output logic             go,
  output frame_req_t       req,
  output logic [DIV_W-1:0] div
);
  logic             c45_q, c45_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [FLD_W-1:0] phy_q, phy_d, dev_q, dev_d;
  logic [PAY_W-1:0] pay_q, pay_d;
  logic             en_mode, en_tgt, en_pay;
  logic [1:0]       code;
  logic             code_ok;
  logic [1:0]       st, op;
  logic             unused_bits;

  assign en_mode = bus_wr && (bus_addr == OFS_MODE);
  assign en_tgt  = bus_wr && (bus_addr == OFS_TGT);
  assign en_pay  = bus_wr && (bus_addr == OFS_PAY);
  assign code    = bus_wdata[1:0];
  assign unused_bits = ^{bus_wdata[31:17], bus_wdata[16], bus_wdata[7:5], bus_wdata[4]};

  always_comb begin
    c45_d = en_mode ? bus_wdata[8] : c45_q;
    div_d = en_mode ? bus_wdata[DIV_W-1:0] : div_q;
    phy_d = en_tgt ? bus_wdata[12:8] : phy_q;
    dev_d = en_tgt ? bus_wdata[FLD_W-1:0] : dev_q;
    pay_d = en_pay ? bus_wdata[PAY_W-1:0] : pay_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c45_q <= 1'b0;
      div_q <= '0;
      phy_q <= '0;
      dev_q <= '0;
      pay_q <= '0;
    end else begin
      c45_q <= c45_d;
      div_q <= div_d;
      phy_q <= phy_d;
      dev_q <= dev_d;
      pay_q <= pay_d;
    end
  end

  // Command decode: start code, opcode and direction per mode
  always_comb begin
    st      = c45_q ? 2'b00 : 2'b01;
    code_ok = 1'b0;
    op      = 2'b00;
    req.rd  = 1'b0;
    if (c45_q) begin
      case (code)
        2'd0: begin op = 2'b00; code_ok = 1'b1; end
        2'd1: begin op = 2'b01; code_ok = 1'b1; end
        2'd2: begin op = 2'b11; code_ok = 1'b1; req.rd = 1'b1; end
        default: code_ok = 1'b0;
      endcase
    end else begin
      case (code)
        2'd0: begin op = 2'b10; code_ok = 1'b1; req.rd = 1'b1; end
        2'd1: begin op = 2'b01; code_ok = 1'b1; end
        default: code_ok = 1'b0;
      endcase
    end
    req.word = {st, op, phy_q, dev_q, 2'b10, (req.rd ? '0 : pay_q)};
  end

  assign go  = bus_wr && (bus_addr == OFS_CMD) && bus_wdata[8] && code_ok && !busy;
  assign div = div_q;

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = {23'd0, c45_q, 4'd0, div_q};
      OFS_TGT:  bus_rdata = {19'd0, phy_q, 3'd0, dev_q};
      OFS_PAY:  bus_rdata = {16'd0, pay_q};
      OFS_RX:   bus_rdata = {16'd0, rx_data};
      OFS_CMD:  bus_rdata = {15'd0, busy, 16'd0};
      default:  bus_rdata = '0;
    endcase
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy); // R2
endmodule

// File: rtl/mgmt_ser_clkdiv.sv
module mgmt_ser_clkdiv
  import mgmt_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  assign wrap = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
endmodule

// File: rtl/mgmt_ser_shifter.sv
module mgmt_ser_shifter
  import mgmt_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  frame_req_t       req,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [PAY_W-1:0] rx_data
);
  localparam int SH_W = FRM_BITS - PRE_BITS;
  localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(PRE_BITS);
  localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(FRM_BITS - PAY_W - 2);
  localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(FRM_BITS - PAY_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRM_BITS - 1);

  logic             busy_q, busy_d;
  logic             rd_q, rd_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PAY_W-1:0] rx_q, rx_d;

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    rx_d   = rx_q;
    if (go) begin
      busy_d = 1'b1;
      rd_d   = req.rd;
      sh_d   = req.word;
      idx_d  = '0;
    end else if (busy_q) begin
      if (rise_tick && rd_q && (idx_q >= IDX_DAT))
        rx_d = {rx_q[PAY_W-2:0], mdio_i};
      if (fall_tick) begin
        if (idx_q == IDX_LAST) busy_d = 1'b0;
        else                   idx_d  = idx_q + 1'b1;
        if (idx_q >= IDX_PRE)  sh_d   = {sh_q[SH_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = !busy_q || (idx_q < IDX_PRE) || sh_q[SH_W-1];
  assign mdio_oe = busy_q && !(rd_q && (idx_q >= IDX_TA));
  assign rx_data = rx_q;

  AST_RX_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(rx_q)); // R8
  AST_IDX_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_tick && !go) |=> $stable(idx_q)); // R9
endmodule

// File: rtl/mgmt_ser_master.sv
module mgmt_ser_master
  import mgmt_ser_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             rst_s1_q, rst_s2_q;
  logic             go, busy, rise_tick, fall_tick;
  logic [DIV_W-1:0] div;
  logic [PAY_W-1:0] rx_data;
  frame_req_t       req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  mgmt_ser_regs u_regs (
    .clk(clk), .rst_n(rst_s2_q), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .rx_data(rx_data), .go(go), .req(req), .div(div)
  );

  mgmt_ser_clkdiv u_div (
    .clk(clk), .rst_n(rst_s2_q), .run(busy), .div(div), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mgmt_ser_shifter u_shift (
    .clk(clk), .rst_n(rst_s2_q), .go(go), .req(req), .rise_tick(rise_tick),
    .fall_tick(fall_tick), .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rx_data(rx_data)
  );

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !busy |-> !mdc); // R9
  AST_DATA_HOLD_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (busy && mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R9
endmodule

// File: tb/mgmt_ser_master_tb.sv
module mgmt_ser_master_tb_top;
  logic        clk, rst_n, bus_wr, mdio_i;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0, fails = 0, nrise = 0, cycles = 0;
  logic        cap_o  [64];
  logic        cap_oe [64];
  logic [15:0] phy_rval = 16'h0;

  mgmt_ser_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // PHY model: records each bit at the rising management clock edge
  always @(posedge mdc) begin
    if (nrise < 64) begin
      cap_o[nrise]  = mdio_o;
      cap_oe[nrise] = mdio_oe;
    end
    nrise = nrise + 1;
  end
  assign mdio_i = (nrise >= 48 && nrise < 64) ? phy_rval[63 - nrise] : 1'b1;

  // {c45, code[1:0], phy[4:0], reg[4:0], payload[15:0], rval[15:0], div[3:0]}
  localparam logic [48:0] VEC [0:5] = '{
    {1'b0, 2'd0, 5'h01, 5'h02, 16'h0000, 16'hA5C3, 4'd0},
    {1'b0, 2'd1, 5'h1F, 5'h00, 16'h1234, 16'h0000, 4'd1},
    {1'b1, 2'd0, 5'h03, 5'h07, 16'hBEEF, 16'h0000, 4'd0},
    {1'b1, 2'd1, 5'h03, 5'h07, 16'h0F0F, 16'h0000, 4'd2},
    {1'b1, 2'd2, 5'h03, 5'h07, 16'h0000, 16'h5AA5, 4'd0},
    {1'b0, 2'd0, 5'h10, 5'h1F, 16'h0000, 16'h0001, 4'd3}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [63:0] exp_frame(input bit c45, input logic [1:0] code,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] pay);
    logic [1:0] st, op;
    bit rdop;
    st = c45 ? 2'b00 : 2'b01;
    if (c45) op = (code == 2'd0) ? 2'b00 : (code == 2'd1) ? 2'b01 : 2'b11;
    else     op = (code == 2'd0) ? 2'b10 : 2'b01;
    rdop = c45 ? (code == 2'd2) : (code == 2'd0);
    return {32'hFFFF_FFFF, st, op, phy, rg, 2'b10, rdop ? 16'h0 : pay};
  endfunction

  // Runs one access; returns busy length in clocks
  task automatic run_op(input bit c45, input logic [1:0] code, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] pay, input logic [15:0] rv,
      input logic [3:0] dv, output int blen);
    logic [31:0] d;
    wr(8'h40, {23'd0, c45, 4'd0, dv} | 32'h0001_5000);
    wr(8'h44, {19'd0, phy, 3'd0, rg});
    wr(8'h48, {16'd0, pay});
    phy_rval = rv;
    nrise = 0;
    wr(8'h50, 32'h100 | {30'd0, code});
    rd(8'h50, d);
    chk(d[16] === 1'b1, "R2 busy after start", d, 32'h1_0000);
    blen = 0;
    while (d[16] === 1'b1 && blen < 5000) begin
      blen++;
      @(negedge clk);
      rd(8'h50, d);
    end
  endtask

  task automatic check_frame(input logic [63:0] ef, input bit rdop, input string req);
    int bad = -1;
    for (int k = 0; k < 64; k++) begin
      if (rdop && k >= 46) begin
        if (cap_oe[k] !== 1'b0 && bad < 0) bad = k;
      end else if ((cap_oe[k] !== 1'b1 || cap_o[k] !== ef[63-k]) && bad < 0) bad = k;
    end
    chk(nrise == 64 && bad < 0, req, {32'(nrise), 32'(bad)}, {32'd64, 32'hFFFF_FFFF});
  endtask

  initial begin
    logic [31:0] d;
    int blen;
    bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(8'h40, d); chk(d == 32'h0, "R1 reset mode", d, 0);
    rd(8'h4C, d); chk(d == 32'h0, "R1 reset rx", d, 0);
    rd(8'h50, d); chk(d == 32'h0, "R1 reset cmd", d, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle lines", {mdc, mdio_oe}, 0);

    // R1 readback keeps only defined fields
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, d);
    chk(d == 32'h0000_010F, "R1 mode fields", d, 32'h10F);
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, d);
    chk(d == 32'h0000_1F1F, "R1 target fields", d, 32'h1F1F);

    // Table walk: R4 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < 6; v++) begin
      logic [48:0] e;
      bit rdop;
      e = VEC[v];
      run_op(e[48], e[47:46], e[45:41], e[40:36], e[35:20], e[19:4], e[3:0], blen);
      rdop = e[48] ? (e[47:46] == 2'd2) : (e[47:46] == 2'd0);
      check_frame(exp_frame(e[48], e[47:46], e[45:41], e[40:36], e[35:20]), rdop,
                  e[48] ? "R6 R7 R11 clause45 frame" : "R4 R5 R11 clause22 frame");
      chk(blen == 128 * (int'(e[3:0]) + 1), "R9 busy length", blen,
          128 * (int'(e[3:0]) + 1));
      if (rdop) begin
        rd(8'h4C, d);
        chk(d == {16'd0, e[19:4]}, "R8 read data", d, {16'd0, e[19:4]});
        repeat (10) @(negedge clk);
        rd(8'h4C, d);
        chk(d == {16'd0, e[19:4]}, "R8 held idle", d, {16'd0, e[19:4]});
      end
    end

    // R3 start during busy is ignored
    wr(8'h40, 32'h0000_0000);
    wr(8'h44, 32'h0000_0203);
    phy_rval = 16'hC001;
    nrise = 0;
    wr(8'h50, 32'h100);
    repeat (20) @(negedge clk);
    wr(8'h50, 32'h101);
    blen = 0;
    rd(8'h50, d);
    while (d[16] === 1'b1 && blen < 5000) begin
      blen++; @(negedge clk); rd(8'h50, d);
    end
    repeat (300) @(negedge clk);
    rd(8'h50, d);
    chk(nrise == 64 && d[16] == 1'b0, "R3 one frame only", nrise, 64);
    rd(8'h4C, d);
    chk(d == 32'h0000_C001, "R3 first read kept", d, 32'hC001);

    // R10 illegal codes
    nrise = 0;
    wr(8'h40, 32'h0000_0000);
    wr(8'h50, 32'h102);
    rd(8'h50, d);
    chk(d[16] == 1'b0, "R10 c22 code2 no busy", d, 0);
    wr(8'h50, 32'h103);
    wr(8'h40, 32'h0000_0100);
    wr(8'h50, 32'h103);
    rd(8'h50, d);
    chk(d[16] == 1'b0, "R10 c45 code3 no busy", d, 0);
    repeat (50) @(negedge clk);
    chk(nrise == 0 && mdc == 1'b0, "R10 no frame sent", nrise, 0);

    finish_run();
  end
endmodule